// File: doc/BRIEF.md
# Remote Data Memory Access Controller

This block gives an external remote processor read and write access to the local data memory through a shared 8-bit multiplexed address/data bus. The remote side starts a cycle with an active-low access enable, an active-low command line and one of two active-low strobes, one for read and one for write. The controller then takes the local bus drivers off the bus and drives the memory read or write strobe for an access phase. It raises a transfer acknowledge when that phase ends.

A 2-bit target select, held in a control register elsewhere, steers each access. Data memory, select code 00, can be reached while the local CPU runs, and the remote side may issue any number of back-to-back accesses without rewriting the select. Any other target is held off until the CPU reports that it has stopped. The access phase lasts one T-state, here one clock. A programmed count of data wait states lengthens it, and so does the external wait input for as long as that input is held low.

Top module: `rdma_ctrl`

## Requirements
- R1: A cycle starts only when `rae_n`, `cmd_n` and at least one of `rrd_n`/`rwr_n` are all low at a clock edge in idle. With `rae_n` or `cmd_n` high, the strobes stay high, `xack` stays low and `loc_oe` stays high.
- R2: `msel` = 2'b00 selects data memory, which is served whether or not `cpu_stopped` is set. The codes 01, 10 and 11 are non-data targets.
- R3: Back-to-back accesses with an unchanged `msel` are each served in full, with no idle cycles needed other than the one after each strobe release.
- R4: `loc_oe` is low from the first access-phase cycle through the last acknowledge cycle, and high in idle and while an access is held off.
- R5: A remote read (`rrd_n` low) asserts `mem_rd_n` and a remote write asserts `mem_wr_n`, one clock after the starting edge. The strobe lasts at least one clock and the other strobe stays high.
- R6: The strobe lasts 1 + `dws` clocks when `wait_n` stays high.
- R7: `wait_n` is sampled only after the programmed waits have expired. Each clock edge that sees it low at that point adds one clock to the strobe.
- R8: `xack` rises in the clock after the last strobe clock and stays high while either remote strobe is low. It falls, and `loc_oe` rises, one clock after both remote strobes are high.
- R9: A non-data target with `cpu_stopped` low is held off, with no memory strobe and `xack` low. The access phase begins one clock after the edge at which `cpu_stopped` is seen high.
- R10: A non-data target with `cpu_stopped` high is served with the same timing as data memory.
- R11: After reset, `loc_oe` = 1, `mem_rd_n` = `mem_wr_n` = 1 and `xack` = 0.
- R12: If both remote strobes are released while an access is held off, the access is dropped, and a later `cpu_stopped` produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is one T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| rae_n | input | 1 | Remote access enable, active low |
| cmd_n | input | 1 | Command line; low selects a memory access |
| rrd_n | input | 1 | Remote read strobe, active low |
| rwr_n | input | 1 | Remote write strobe, active low |
| msel | input | 2 | Target select from the control register |
| dws | input | 2 | Programmed data wait states (0 to 3) |
| wait_n | input | 1 | External wait, active low |
| cpu_stopped | input | 1 | High when the local CPU is stopped |
| loc_oe | output | 1 | Local address/data driver enable |
| mem_rd_n | output | 1 | Data memory read strobe, active low |
| mem_wr_n | output | 1 | Data memory write strobe, active low |
| xack | output | 1 | Transfer acknowledge |

## Verification
A start seen at edge e0 lowers the memory strobe and `loc_oe` in the cycle after e0. The strobe then stays low for 1 + `dws` + the number of low wait samples. `xack` rises one clock after the strobe's last cycle, and it falls one clock after the remote strobes are released. The bench drives every input on the falling edge and samples once per falling edge. It counts strobe-low cycles up to the first `xack` cycle and compares the count with the sum computed from the vector, so each result is read in the half-cycle after the register that produces it has updated. Hold-off and ignored cases are checked over several cycles at the same sampling point.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_ACC  = 2'd2,
      ST_ACK  = 2'd3
   } rdma_state_e;
endpackage

// File: rtl/rdma_decode.sv
module rdma_decode #(
   parameter int MSEL_W   = 2,
   parameter int DMEM_SEL = 0
) (
   input  logic              rae_n,
   input  logic              cmd_n,
   input  logic              rrd_n,
   input  logic              rwr_n,
   input  logic [MSEL_W-1:0] msel,
   input  logic              cpu_stopped,
   output logic              start,
   output logic              is_read,
   output logic              allowed,
   output logic              released
);
   localparam logic [MSEL_W-1:0] DMEM_CODE = MSEL_W'(DMEM_SEL);

   initial begin
      if (MSEL_W < 1 || DMEM_SEL >= (1 << MSEL_W))
         $error("rdma_decode: select code does not fit the select width");
   end

   always_comb begin
      start    = !rae_n && !cmd_n && (!rrd_n || !rwr_n);
      is_read  = !rrd_n;
      allowed  = (msel == DMEM_CODE) || cpu_stopped;
      released = rrd_n && rwr_n;
   end
endmodule

// File: rtl/rdma_waitcnt.sv
module rdma_waitcnt #(
   parameter int WS_W         = 2,
   parameter bit USE_EXT_WAIT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            run,
   input  logic [WS_W-1:0] dws,
   input  logic            wait_n,
   output logic            done
);
   localparam logic [WS_W-1:0] ZERO = '0;

   logic [WS_W-1:0] cnt;
   logic            prog_done;

   initial begin
      if (WS_W < 1 || WS_W > 8)
         $error("rdma_waitcnt: wait-state width out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= ZERO;
      else if (load)
         cnt <= dws;
      else if (run && cnt != ZERO)
         cnt <= cnt - 1'b1;
   end

   assign prog_done = (cnt == ZERO);

   generate
      if (USE_EXT_WAIT) begin : g_ext_wait
         assign done = prog_done && wait_n;
      end else begin : g_prog_only
         assign done = prog_done;
      end
   endgenerate

   // R6: each programmed wait state costs exactly one clock
   p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && cnt != ZERO) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
   import rdma_pkg::*;
#(
   parameter int MSEL_W       = 2,
   parameter int DMEM_SEL     = 0,
   parameter int WS_W         = 2,
   parameter bit USE_EXT_WAIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rae_n,
   input  logic              cmd_n,
   input  logic              rrd_n,
   input  logic              rwr_n,
   input  logic [MSEL_W-1:0] msel,
   input  logic [WS_W-1:0]   dws,
   input  logic              wait_n,
   input  logic              cpu_stopped,
   output logic              loc_oe,
   output logic              mem_rd_n,
   output logic              mem_wr_n,
   output logic              xack
);
   rdma_state_e state, state_nx;
   logic        rd_q;
   logic        start, is_read, allowed, released;
   logic        wdone, wload, wrun;

   rdma_decode #(.MSEL_W(MSEL_W), .DMEM_SEL(DMEM_SEL)) u_decode (
      .rae_n       (rae_n),
      .cmd_n       (cmd_n),
      .rrd_n       (rrd_n),
      .rwr_n       (rwr_n),
      .msel        (msel),
      .cpu_stopped (cpu_stopped),
      .start       (start),
      .is_read     (is_read),
      .allowed     (allowed),
      .released    (released)
   );

   assign wload = (state == ST_IDLE) || (state == ST_HOLD);
   assign wrun  = (state == ST_ACC);

   rdma_waitcnt #(.WS_W(WS_W), .USE_EXT_WAIT(USE_EXT_WAIT)) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (wload),
      .run    (wrun),
      .dws    (dws),
      .wait_n (wait_n),
      .done   (wdone)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (start) state_nx = allowed ? ST_ACC : ST_HOLD;
         ST_HOLD: begin
            if (released)         state_nx = ST_IDLE;
            else if (cpu_stopped) state_nx = ST_ACC;
         end
         ST_ACC:  if (wdone)    state_nx = ST_ACK;
         ST_ACK:  if (released) state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         rd_q  <= 1'b0;
      end else begin
         state <= state_nx;
         if (state == ST_IDLE && start)
            rd_q <= is_read;
      end
   end

   always_comb begin
      loc_oe   = (state == ST_IDLE) || (state == ST_HOLD);
      mem_rd_n = !((state == ST_ACC) && rd_q);
      mem_wr_n = !((state == ST_ACC) && !rd_q);
      xack     = (state == ST_ACK);
   end

   // R1: an allowed start in idle produces a strobe on the next clock
   p_start_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start && allowed) |=> (!mem_rd_n || !mem_wr_n));

   // R9: while held off with the CPU running, nothing reaches memory
   p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && !cpu_stopped) |=> (mem_rd_n && mem_wr_n && !xack));

   // R6: the strobe continues while the wait logic is not done
   p_strobe_stretch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((!mem_rd_n || !mem_wr_n) && !wdone) |=> (!mem_rd_n || !mem_wr_n));

   // R8: acknowledge follows a strobe and holds until release
   p_ack_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xack) |-> $past(!mem_rd_n || !mem_wr_n));
   p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (xack && !released) |=> xack);

   // R4: the local drivers stay off across the strobe-to-ack boundary
   p_bus_handover_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xack) |-> (!loc_oe && $past(!loc_oe)));
endmodule

// File: tb/rdma_ctrl_tb.sv
module rdma_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       rae_n, cmd_n, rrd_n, rwr_n;
   logic [1:0] msel, dws;
   logic       wait_n, cpu_stopped;
   logic       loc_oe, mem_rd_n, mem_wr_n, xack;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk;

   rdma_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .rae_n(rae_n), .cmd_n(cmd_n),
      .rrd_n(rrd_n), .rwr_n(rwr_n), .msel(msel), .dws(dws),
      .wait_n(wait_n), .cpu_stopped(cpu_stopped), .loc_oe(loc_oe),
      .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .xack(xack)
   );

   // Vector: {is_rd, msel[1:0], dws[1:0], wait_extra[1:0], cpu_stopped, expected_len[2:0]}
   localparam logic [10:0] VECS [8] = '{
      {1'b1, 2'b00, 2'd0, 2'd0, 1'b0, 3'd1},
      {1'b0, 2'b00, 2'd0, 2'd0, 1'b0, 3'd1},
      {1'b1, 2'b00, 2'd3, 2'd0, 1'b0, 3'd4},
      {1'b0, 2'b00, 2'd2, 2'd1, 1'b0, 3'd4},
      {1'b1, 2'b00, 2'd1, 2'd3, 1'b0, 3'd5},
      {1'b0, 2'b11, 2'd0, 2'd0, 1'b1, 3'd1},
      {1'b1, 2'b10, 2'd2, 2'd2, 1'b1, 3'd5},
      {1'b0, 2'b01, 2'd3, 2'd3, 1'b1, 3'd7}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle_bus();
      rae_n = 1'b1; cmd_n = 1'b1; rrd_n = 1'b1; rwr_n = 1'b1;
   endtask

   // Runs one access already allowed (or started from hold by the caller)
   task automatic finish_access(input bit is_rd, input int d, input int w,
                                input int exp_len, input string req);
      int  cnt = 0;
      bit  seen_ack = 1'b0;
      bit  wrong_strobe = 1'b0;
      bit  oe_bad = 1'b0;
      wait_n = (w == 0);
      for (int i = 0; i < 20 && !seen_ack; i++) begin
         @(negedge clk);
         if (xack) begin
            seen_ack = 1'b1;
            if (!mem_rd_n || !mem_wr_n) wrong_strobe = 1'b1;
         end else if (!mem_rd_n || !mem_wr_n) begin
            cnt++;
            if (is_rd ? !mem_wr_n : !mem_rd_n) wrong_strobe = 1'b1;
         end
         if ((!mem_rd_n || !mem_wr_n || xack) && loc_oe) oe_bad = 1'b1;
         wait_n = (cnt >= d + w + 1);
      end
      wait_n = 1'b1;
      check(seen_ack, {req, " R8 ack seen"}, seen_ack, 1);
      check(cnt == exp_len, {req, " R6 R7 strobe length"}, cnt, exp_len);
      check(!wrong_strobe, {req, " R5 strobe direction"}, wrong_strobe, 0);
      check(!oe_bad, {req, " R4 drivers off"}, oe_bad, 0);
      @(negedge clk);
      check(xack && !loc_oe, {req, " R8 ack held"}, xack, 1);
      idle_bus();
      @(negedge clk);
      check(!xack && loc_oe, {req, " R8 ack dropped after release"}, xack, 0);
   endtask

   task automatic start_access(input bit is_rd, input logic [1:0] ms, input logic [1:0] d);
      msel = ms; dws = d;
      rae_n = 1'b0; cmd_n = 1'b0;
      rrd_n = !is_rd; rwr_n = is_rd;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; idle_bus(); msel = 2'b00; dws = 2'd0;
      wait_n = 1'b1; cpu_stopped = 1'b0;
      repeat (3) @(negedge clk);
      // R11 reset state
      check(loc_oe && mem_rd_n && mem_wr_n && !xack, "R11 reset outputs", loc_oe, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector walk: back-to-back accesses (R2 R3 R5 R6 R7 R10)
      for (int k = 0; k < 8; k++) begin
         cpu_stopped = VECS[k][3];
         start_access(VECS[k][10], VECS[k][9:8], VECS[k][7:6]);
         finish_access(VECS[k][10], int'(VECS[k][7:6]), int'(VECS[k][5:4]),
                       int'(VECS[k][2:0]), $sformatf("R3 vec%0d", k));
      end

      // R1: enable high or command high start nothing
      cpu_stopped = 1'b1;
      msel = 2'b00; dws = 2'd0;
      rae_n = 1'b1; cmd_n = 1'b0; rrd_n = 1'b0; rwr_n = 1'b1;
      begin
         bit quiet = 1'b1;
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!mem_rd_n || !mem_wr_n || xack || !loc_oe) quiet = 1'b0;
         end
         check(quiet, "R1 enable high ignored", quiet, 1);
         rae_n = 1'b0; cmd_n = 1'b1; rrd_n = 1'b1; rwr_n = 1'b0;
         quiet = 1'b1;
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!mem_rd_n || !mem_wr_n || xack || !loc_oe) quiet = 1'b0;
         end
         check(quiet, "R1 command high ignored", quiet, 1);
      end
      idle_bus();
      @(negedge clk);

      // R2: data memory runs with CPU running
      cpu_stopped = 1'b0;
      start_access(1'b0, 2'b00, 2'd1);
      finish_access(1'b0, 1, 0, 2, "R2 dmem cpu running");

      // R9: non-data target held off, then released by cpu stop
      start_access(1'b1, 2'b10, 2'd0);
      begin
         bit quiet = 1'b1;
         for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!mem_rd_n || !mem_wr_n || xack || !loc_oe) quiet = 1'b0;
         end
         check(quiet, "R9 held off while running", quiet, 1);
      end
      cpu_stopped = 1'b1;
      finish_access(1'b1, 0, 0, 1, "R9 after stop");

      // R12: held-off access dropped on release
      cpu_stopped = 1'b0;
      start_access(1'b0, 2'b01, 2'd0);
      repeat (2) @(negedge clk);
      idle_bus();
      @(negedge clk);
      cpu_stopped = 1'b1;
      begin
         bit quiet = 1'b1;
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!mem_rd_n || !mem_wr_n || xack || !loc_oe) quiet = 1'b0;
         end
         check(quiet, "R12 dropped access", quiet, 1);
      end

      // R7: wait low before programmed waits expire does not add time
      start_access(1'b1, 2'b00, 2'd2);
      wait_n = 1'b0;
      @(negedge clk);
      check(!mem_rd_n, "R5 read strobe one clock after start", mem_rd_n, 0);
      @(negedge clk);
      wait_n = 1'b1;
      begin
         int cnt = 2;
         while (!xack && cnt < 10) begin
            @(negedge clk);
            if (!mem_rd_n) cnt++;
         end
         check(cnt == 3, "R7 early wait ignored", cnt, 3);
      end
      idle_bus();
      @(negedge clk);
      check(!xack && loc_oe, "R8 return to idle", xack, 0);

      done_flag = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule